// File: doc/BRIEF.md
# Three-Table Configurable Logic Cell

This block is a small programmable logic cell. It holds two 16-entry truth tables and one 8-entry truth table. The two wide tables are addressed by their own four input lines each, and their results appear on `outX` and `outZ`. The narrow table drives `outY`. Each of its three address bits is chosen by static selects. The first two address bits can come either from a wide-table result or from one of three general lines `cIn`. The third address bit always comes from one of the `cIn` lines. With these selects the cell can compute three unrelated functions at once. It can also compute any function of five variables, or certain functions of six or nine variables, by merging the wide-table results in the narrow table.

The truth tables and selects are loaded serially, one bit per clock while `cfgEn` is high. The loaded bits collect in a shift register. The cell keeps using its previous configuration until a complete 48-bit word has arrived. At that point the word is copied into the active configuration in a single step. The logic path from the data inputs to the outputs is purely combinational. Only the configuration is clocked.

Top module: `lutcell`

## Requirements
- R1: After the asynchronous active-low reset, every table bit and select is 0, so `outX`, `outY` and `outZ` are 0 for every input pattern.
- R2: `outX` equals entry `fIn` of the F table, and `outZ` equals entry `gIn` of the G table. In each case the input vector is read as an unsigned index with bit 0 as the least significant bit.
- R3: A configuration word has 48 bits and is shifted in most significant bit first. Its fields, from bit 47 down to bit 0, are:
  - F table [47:32]
  - G table [31:16]
  - H table [15:8]
  - selA [7]
  - selB [6]
  - pickA [5:4]
  - pickB [3:2]
  - pickC [1:0]

  The word takes effect combinationally right after the clock edge that samples its 48th consecutive bit with `cfgEn` high.
- R4: While a word is being shifted, the outputs keep following the previous active configuration. If `cfgEn` is low on an edge, any partly shifted word is discarded and the bit count restarts from zero.
- R5: H address bit 0 is `outX` when selA=0. When selA=1 it is the `cIn` line chosen by pickA.
- R6: H address bit 1 is `outZ` when selB=0. When selB=1 it is the `cIn` line chosen by pickB.
- R7: H address bit 2 is the `cIn` line chosen by pickC. For pickA, pickB and pickC alike, code 0 selects `cIn[0]`, code 1 selects `cIn[1]`, code 2 selects `cIn[2]`, and code 3 selects `cIn[0]`.
- R8: `outY` equals entry {bit2, bit1, bit0} of the H table.
- R9: Five-input mode uses selA=0, selB=0 and pickC=0, with the H table set to 8'hAC. The F table holds a five-input function with its fifth variable at 1, and the G table holds the same function with its fifth variable at 0. With `fIn` and `gIn` tied together and `cIn[0]` as the fifth variable, `outY` then equals that five-input function for all 32 patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEn | input | 1 | Configuration shift enable |
| cfgData | input | 1 | Serial configuration bit |
| fIn | input | 4 | F table address lines |
| gIn | input | 4 | G table address lines |
| cIn | input | 3 | General lines for the H table selects |
| outX | output | 1 | F table result |
| outY | output | 1 | H table result |
| outZ | output | 1 | G table result |

## Verification
Loading and evaluation overlap in two ways. Evaluation continues on the old configuration while new bits are shifting. In the cycle that samples the final bit, the new word is committed while evaluation carries on. The bench provokes both by changing the data inputs on every cycle of a load and by aborting one load partway through. A behavioural model, which tracks the serial bits in a queue, predicts all three outputs on every cycle. Any early, late or partial switch of configuration therefore shows up as a mismatch.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  localparam int WIDE_IN        = 4;
  localparam int NARROW_IN      = 3;
  localparam int C_LINES        = 3;
  localparam int PICK_W         = 2;
  localparam int WIDE_ENTRIES   = 1 << WIDE_IN;
  localparam int NARROW_ENTRIES = 1 << NARROW_IN;
  localparam int WIDE_TABLES    = 2;

  typedef struct packed {
    logic [WIDE_ENTRIES-1:0]   fTab;
    logic [WIDE_ENTRIES-1:0]   gTab;
    logic [NARROW_ENTRIES-1:0] hTab;
    logic                      selA;
    logic                      selB;
    logic [PICK_W-1:0]         pickA;
    logic [PICK_W-1:0]         pickB;
    logic [PICK_W-1:0]         pickC;
  } cellCfg_t;

  localparam int CHAIN_LEN = $bits(cellCfg_t);

  typedef struct packed {
    logic shift;
    logic commit;
  } cfgStrobe_t;
endpackage

// File: rtl/lutcell_lut.sv
module lutcell_lut #(
  parameter int IN_W = 4,
  localparam int ENTRIES = 1 << IN_W
) (
  input  logic [ENTRIES-1:0] tab,
  input  logic [IN_W-1:0]    addr,
  output logic               dataOut
);
  always_comb dataOut = tab[addr];
endmodule

// File: rtl/lutcell_ctrl.sv
module lutcell_ctrl
  import lutcell_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEn,
  output cfgStrobe_t strobe
);
  localparam int CNT_W = $clog2(CHAIN_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAIN_LEN - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             atLast;

  always_comb atLast = (bitCnt == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        bitCnt <= '0;
    else if (!cfgEn)  bitCnt <= '0;
    else if (atLast)  bitCnt <= '0;
    else              bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe.shift  = cfgEn;
    strobe.commit = cfgEn && atLast;
  end

  // R3: the counter never runs past the last bit of a word
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_IDX);

  // R4: a gap in the enable restarts the count
  assert_abort_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> !strobe.commit);
endmodule

// File: rtl/lutcell_dp.sv
module lutcell_dp
  import lutcell_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strobe,
  input  logic                 cfgData,
  input  logic [WIDE_IN-1:0]   fIn,
  input  logic [WIDE_IN-1:0]   gIn,
  input  logic [C_LINES-1:0]   cIn,
  output logic                 outX,
  output logic                 outY,
  output logic                 outZ
);
  logic [CHAIN_LEN-2:0] shiftReg;
  cellCfg_t             active;
  logic [CHAIN_LEN-1:0] nextWord;

  always_comb nextWord = {shiftReg, cfgData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      active   <= '0;
    end else begin
      if (strobe.shift)  shiftReg <= nextWord[CHAIN_LEN-2:0];
      if (strobe.commit) active   <= cellCfg_t'(nextWord);
    end
  end

  function automatic logic pickLine(input logic [PICK_W-1:0] sel,
                                    input logic [C_LINES-1:0] lines);
    case (sel)
      2'd1:    return lines[1];
      2'd2:    return lines[2];
      default: return lines[0];
    endcase
  endfunction

  logic [WIDE_ENTRIES-1:0] wideTab  [WIDE_TABLES];
  logic [WIDE_IN-1:0]      wideAddr [WIDE_TABLES];
  logic                    wideOut  [WIDE_TABLES];

  always_comb begin
    wideTab[0]  = active.fTab;
    wideTab[1]  = active.gTab;
    wideAddr[0] = fIn;
    wideAddr[1] = gIn;
  end

  for (genvar t = 0; t < WIDE_TABLES; t++) begin : gWide
    lutcell_lut #(.IN_W(WIDE_IN)) uLut (
      .tab(wideTab[t]), .addr(wideAddr[t]), .dataOut(wideOut[t]));
  end

  logic [NARROW_IN-1:0] hAddr;
  logic                 hOut;

  always_comb begin
    hAddr[0] = active.selA ? pickLine(active.pickA, cIn) : wideOut[0];
    hAddr[1] = active.selB ? pickLine(active.pickB, cIn) : wideOut[1];
    hAddr[2] = pickLine(active.pickC, cIn);
  end

  lutcell_lut #(.IN_W(NARROW_IN)) uNarrow (
    .tab(active.hTab), .addr(hAddr), .dataOut(hOut));

  always_comb begin
    outX = wideOut[0];
    outZ = wideOut[1];
    outY = hOut;
  end

  // R4: active configuration changes only on a commit strobe
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(active));

  // R3: a commit captures the completed serial word
  assert_commit_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (active == $past(nextWord)));

  // R9: in merge mode the narrow table acts as a 2:1 mux steered by cIn[0]
  assert_merge_mux_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!active.selA && !active.selB && active.pickC == 2'd0 && active.hTab == 8'hAC)
      |-> (outY == (cIn[0] ? outX : outZ)));
endmodule

// File: rtl/lutcell.sv
module lutcell
  import lutcell_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgEn,
  input  logic                cfgData,
  input  logic [WIDE_IN-1:0]  fIn,
  input  logic [WIDE_IN-1:0]  gIn,
  input  logic [C_LINES-1:0]  cIn,
  output logic                outX,
  output logic                outY,
  output logic                outZ
);
  cfgStrobe_t strobe;

  lutcell_ctrl uCtrl (.clk(clk), .rstN(rstN), .cfgEn(cfgEn), .strobe(strobe));

  lutcell_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgData(cfgData),
    .fIn(fIn), .gIn(gIn), .cIn(cIn),
    .outX(outX), .outY(outY), .outZ(outZ));
endmodule

// File: tb/tb_lutcell.sv
module tb_lutcell;
  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEn = 1'b0;
  logic cfgData = 1'b0;
  logic [3:0] fIn = '0, gIn = '0;
  logic [2:0] cIn = '0;
  logic outX, outY, outZ;

  int checks = 0;
  int fails  = 0;

  lutcell dut (.clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgData(cfgData),
               .fIn(fIn), .gIn(gIn), .cIn(cIn),
               .outX(outX), .outY(outY), .outZ(outZ));

  always #(CLK_NS/2) clk = ~clk;

  // Behavioural model: serial bits collect in a queue, full word replaces config
  bit          bitQ[$];
  logic [47:0] mCfg = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCfg = '0;
      bitQ.delete();
    end else if (cfgEn) begin
      bitQ.push_back(cfgData);
      if (bitQ.size() == 48) begin
        logic [47:0] w;
        w = '0;
        foreach (bitQ[k]) w = {w[46:0], bitQ[k]};
        mCfg = w;
        bitQ.delete();
      end
    end else begin
      bitQ.delete();
    end
  end

  function automatic logic lineOf(input logic [1:0] code, input logic [2:0] c);
    if (code == 2'd1) return c[1];
    if (code == 2'd2) return c[2];
    return c[0];
  endfunction

  function automatic logic [2:0] modelOut();
    logic x, z, a0, a1, a2;
    logic [15:0] ft, gt;
    logic [7:0]  ht;
    ft = mCfg[47:32]; gt = mCfg[31:16]; ht = mCfg[15:8];
    x  = ft[fIn];
    z  = gt[gIn];
    a0 = mCfg[7] ? lineOf(mCfg[5:4], cIn) : x;
    a1 = mCfg[6] ? lineOf(mCfg[3:2], cIn) : z;
    a2 = lineOf(mCfg[1:0], cIn);
    return {x, ht[{a2, a1, a0}], z};
  endfunction

  task automatic check(input string tag);
    logic [2:0] exp;
    exp = modelOut();
    checks++;
    if ({outX, outY, outZ} !== exp) begin
      fails++;
      $display("FAIL %s: XYZ=%b expected %b (f=%h g=%h c=%b)",
               tag, {outX, outY, outZ}, exp, fIn, gIn, cIn);
    end
  endtask

  task automatic step(input logic [10:0] v, input logic en, input logic d,
                      input string tag);
    @(negedge clk);
    {cIn, gIn, fIn} = v;
    cfgEn = en;
    cfgData = d;
    #1;
    check(tag);
  endtask

  // R3 R4: shift a word MSB first while data inputs keep moving
  task automatic loadCfg(input logic [47:0] w);
    for (int i = 47; i >= 0; i--)
      step(11'(i * 37 + 5), 1'b1, w[i], "R3/R4 load");
    step(11'h2A5, 1'b0, 1'b0, "R3 post-commit");
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 2048; i++) step(11'(i), 1'b0, 1'b0, tag);
  endtask

  function automatic logic ref5(input logic [4:0] a);
    return (a[0] & a[1]) | (a[2] ^ a[3] ^ a[4]);
  endfunction

  initial begin
    #(CLK_NS * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] f5, g5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents give zeros for any pattern
    for (int i = 0; i < 16; i++) begin
      step(11'(i * 131), 1'b0, 1'b0, "R1 model");
      checks++;
      if ({outX, outY, outZ} !== 3'b000) begin
        fails++;
        $display("FAIL R1: XYZ=%b expected 000", {outX, outY, outZ});
      end
    end

    // Independent functions: parity, corner pattern, majority of C lines
    loadCfg({16'h6996, 16'h8001, 8'hE8, 1'b1, 1'b1, 2'd0, 2'd1, 2'd2});
    sweep("R2/R5/R6/R7/R8 independent");

    // Aborted load must leave configuration alone
    for (int i = 0; i < 20; i++) step(11'(i * 91), 1'b1, i[0], "R4 partial");
    step(11'h155, 1'b0, 1'b0, "R4 abort gap");
    sweep("R4 after abort");

    // Code 3 on every pick, Y = C1 ^ Z ^ C1 = Z
    loadCfg({16'hA5C3, 16'h3CF0, 8'h96, 1'b1, 1'b0, 2'd3, 2'd0, 2'd3});
    sweep("R6/R7 code three");

    // Mixed routing: X into bit0, C3 into bit1, C2 into bit2
    loadCfg({16'h1E2D, 16'hFFFF, 8'h6A, 1'b0, 1'b1, 2'd1, 2'd2, 2'd1});
    sweep("R5/R6/R7/R8 mixed");

    // R9 five-input mode
    for (int k = 0; k < 16; k++) begin
      f5[k] = ref5({1'b1, 4'(k)});
      g5[k] = ref5({1'b0, 4'(k)});
    end
    loadCfg({f5, g5, 8'hAC, 1'b0, 1'b0, 2'd3, 2'd3, 2'd0});
    for (int j = 0; j < 128; j++) begin
      logic [3:0] a;
      a = 4'(j);
      step({j[6:5], j[4], a, a}, 1'b0, 1'b0, "R9 model");
      checks++;
      if (outY !== ref5({j[4], a})) begin
        fails++;
        $display("FAIL R9: Y=%b expected %b for a=%b", outY, ref5({j[4], a}), {j[4], a});
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule